// File: doc/BRIEF.md
# Access Combining Translator

This block sits on the far side of a bus bridge. It takes one upstream access descriptor: direction, transfer size code, single or burst, incoming burst length, a prefetchable-region flag and a start address. It decides how many downstream beats that access becomes, what size each beat has, and whether idle (BUSY) cycles go between beats. A small sequencer then drives the downstream address-phase signals beat by beat. Downstream wait states stall it.

There are four cases. Single accesses of 32 bits or less pass through unchanged. Wider single accesses are cut into bursts of 32-bit words. Read bursts to a prefetchable region are sized to the read buffer and stop at a fixed address boundary. Read bursts to other regions keep their length and are paced by BUSY cycles. Write bursts keep their length, limited to the write FIFO depth. Data buffering and response handling live elsewhere.

Top module: `access_combiner`

## Requirements
- R1: After reset, `reqReady` is 1, `dnHtrans` is IDLE (2'b00) and `dnHburst` is 3'b000.
- R2: A single access (`reqBurst`=0) of size code 0, 1 or 2 (byte, halfword, word), read or write, becomes exactly one beat of the same size code at the request address.
- R3: A single access of size code 3 to 7 (64 to 1024 bits), read or write, becomes 2^(code-2) beats of size code 2, with addresses stepping by 4 from the request address.
- R4: A read burst with `reqPrefetch`=1 becomes min(RBUF_WORDS, (BOUNDARY - addr mod BOUNDARY) >> size) beats, at least one, so it never crosses a BOUNDARY-byte aligned edge. Its length ignores `reqLen`.
- R5: A read burst with `reqPrefetch`=0 becomes `reqLen` beats with one BUSY (2'b01) cycle between consecutive beats. During that cycle the address already shows the next beat.
- R6: A write burst becomes min(`reqLen`, WFIFO_WORDS) beats with no BUSY cycles, and `reqPrefetch` has no effect on it.
- R7: The first beat is NONSEQ (2'b10) and later beats are SEQ (2'b11). Each beat's address is the previous one plus 2^size bytes. `dnHburst` is INCR (3'b001) whenever `dnHtrans` is not IDLE.
- R8: A burst with `reqLen`=0 is treated as a length of one beat.
- R9: While `dnHready` is 0 during a transfer, `dnHtrans`, `dnHaddr` and `dnHsize` hold their values.
- R10: `reqReady` is 0 from the edge that accepts a request until the edge that completes the last beat. A `reqValid` raised during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Upstream access descriptor valid |
| reqReady | output | 1 | Idle, able to accept a descriptor |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 3 | Size code, bytes = 2^code |
| reqBurst | input | 1 | 1 = burst, 0 = single |
| reqLen | input | LEN_W | Incoming burst length in beats |
| reqPrefetch | input | 1 | Target region is prefetchable |
| reqAddr | input | ADDR_W | Start address |
| dnHtrans | output | 2 | Downstream transfer type |
| dnHaddr | output | ADDR_W | Downstream beat address |
| dnHsize | output | 3 | Downstream beat size code |
| dnHburst | output | 3 | Downstream burst type |
| dnHready | input | 1 | Downstream address phase accepted |

## Verification
The table of descriptors covers the four translation cases. Byte, halfword and word singles show that narrow accesses pass through. 64, 256 and 128-bit singles, the last one a write, show the split into words. Prefetch bursts are placed at an aligned start, 6 bytes before the boundary and 2 bytes before it, which separates the buffer-depth limit from the boundary limit. Non-prefetch bursts check BUSY pacing and the zero-length rule. Write bursts are sent with a length above the FIFO depth and with the prefetch flag set at an address where a prefetch read would give a different count, so a design that confused the cases shows a different beat count. Directed runs stall a beat with `dnHready` low and raise `reqValid` during a transfer.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [2:0] BURST_INCR   = 3'b001;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new plan
    logic step;   // move to the next beat
  } acc_ctl_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/acc_translate.sv
module acc_translate #(
  parameter int LEN_W       = 5,
  parameter int CNT_W       = 6,
  parameter int RBUF_WORDS  = 8,
  parameter int WFIFO_WORDS = 8,
  parameter int BOUNDARY    = 32,
  localparam int OFF_W      = $clog2(BOUNDARY)
) (
  input  logic             reqWrite,
  input  logic [2:0]       reqSize,
  input  logic             reqBurst,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             reqPrefetch,
  input  logic [OFF_W-1:0] reqOffset,
  output logic [CNT_W-1:0] planLen,
  output logic [2:0]       planSize,
  output logic             planGap
);

  localparam logic [CNT_W-1:0] RBUF_C  = CNT_W'(RBUF_WORDS);
  localparam logic [CNT_W-1:0] WFIFO_C = CNT_W'(WFIFO_WORDS);

  logic             wideAccess;
  logic [2:0]       beatSize;
  logic [OFF_W:0]   bytesLeft;
  logic [CNT_W-1:0] lenNz;
  logic [CNT_W-1:0] edgeBeats;

  always_comb begin
    wideAccess = reqSize > 3'd2;
    beatSize   = wideAccess ? 3'd2 : reqSize;
    bytesLeft  = (OFF_W+1)'(BOUNDARY) - {1'b0, reqOffset};
    lenNz      = (reqLen == '0) ? CNT_W'(1) : CNT_W'(reqLen);
    edgeBeats  = CNT_W'(bytesLeft >> beatSize);
    if (edgeBeats == '0) edgeBeats = CNT_W'(1);

    planSize = beatSize;
    planGap  = 1'b0;
    if (!reqBurst) begin
      planLen = wideAccess ? (CNT_W'(1) << (reqSize - 3'd2)) : CNT_W'(1);
    end else if (reqWrite) begin
      planLen = (lenNz > WFIFO_C) ? WFIFO_C : lenNz;
    end else if (reqPrefetch) begin
      planLen = (edgeBeats > RBUF_C) ? RBUF_C : edgeBeats;
    end else begin
      planLen = lenNz;
      planGap = 1'b1;
    end
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  acc_ctl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  planLen,
  input  logic [2:0]        planSize,
  input  logic              planGap,
  output logic [ADDR_W-1:0] curAddr,
  output logic [2:0]        curSize,
  output logic              gapMode,
  output logic              lastBeat
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curSize <= '0;
      gapMode <= 1'b0;
      remain  <= '0;
    end else if (ctl.load) begin
      curAddr <= reqAddr;
      curSize <= planSize;
      gapMode <= planGap;
      remain  <= planLen;
    end else if (ctl.step) begin
      curAddr <= curAddr + (ADDR_W'(1) << curSize);
      remain  <= remain - CNT_W'(1);
    end
  end

  assign lastBeat = (remain == CNT_W'(1));

  AST_NONZERO_PLAN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> (planLen != '0)) else $error("plan length zero"); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> (remain > CNT_W'(1))) else $error("step past last beat"); // R7

endmodule

// File: rtl/acc_control.sv
module acc_control
  import acc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     dnHready,
  input  logic     lastBeat,
  input  logic     gapMode,
  output acc_ctl_t ctl,
  output logic     reqReady,
  output htrans_e  transOut
);

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_GAP} state_e;

  state_e state;
  logic   firstBeat;

  always_comb begin
    ctl.load = (state == ST_IDLE) && reqValid;
    ctl.step = (state == ST_BEAT) && dnHready && !lastBeat;
    reqReady = (state == ST_IDLE);
    case (state)
      ST_BEAT: transOut = firstBeat ? TR_NONSEQ : TR_SEQ;
      ST_GAP:  transOut = TR_BUSY;
      default: transOut = TR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstBeat <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state     <= ST_BEAT;
          firstBeat <= 1'b1;
        end
        ST_BEAT: if (dnHready) begin
          firstBeat <= 1'b0;
          if (lastBeat)     state <= ST_IDLE;
          else if (gapMode) state <= ST_GAP;
        end
        ST_GAP: if (dnHready) state <= ST_BEAT;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_TRANS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !dnHready) |=> $stable(transOut)) else $error("trans moved in wait"); // R9

  AST_BUSY_ONLY_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (transOut == TR_BUSY) |-> gapMode) else $error("BUSY outside paced burst"); // R5

endmodule

// File: rtl/access_combiner.sv
module access_combiner
  import acc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 5,
  parameter int RBUF_WORDS  = 8,
  parameter int WFIFO_WORDS = 8,
  parameter int BOUNDARY    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [2:0]        reqSize,
  input  logic              reqBurst,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqPrefetch,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        dnHtrans,
  output logic [ADDR_W-1:0] dnHaddr,
  output logic [2:0]        dnHsize,
  output logic [2:0]        dnHburst,
  input  logic              dnHready
);

  localparam int OFF_W = $clog2(BOUNDARY);
  localparam int CNT_W = maxInt(maxInt(LEN_W, 6),
                         maxInt(maxInt($clog2(RBUF_WORDS+1), $clog2(WFIFO_WORDS+1)),
                                $clog2(BOUNDARY+1)));

  acc_ctl_t         ctl;
  htrans_e          transOut;
  logic [CNT_W-1:0] planLen;
  logic [2:0]       planSize;
  logic             planGap;
  logic             gapMode;
  logic             lastBeat;

  acc_translate #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .RBUF_WORDS(RBUF_WORDS),
    .WFIFO_WORDS(WFIFO_WORDS), .BOUNDARY(BOUNDARY)
  ) uTranslate (
    .reqWrite(reqWrite), .reqSize(reqSize), .reqBurst(reqBurst),
    .reqLen(reqLen), .reqPrefetch(reqPrefetch),
    .reqOffset(reqAddr[OFF_W-1:0]),
    .planLen(planLen), .planSize(planSize), .planGap(planGap)
  );

  acc_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDatapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .planLen(planLen), .planSize(planSize), .planGap(planGap),
    .curAddr(dnHaddr), .curSize(dnHsize), .gapMode(gapMode), .lastBeat(lastBeat)
  );

  acc_control uControl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .dnHready(dnHready),
    .lastBeat(lastBeat), .gapMode(gapMode), .ctl(ctl),
    .reqReady(reqReady), .transOut(transOut)
  );

  assign dnHtrans = transOut;
  assign dnHburst = (transOut == TR_IDLE) ? BURST_SINGLE : BURST_INCR;

  AST_FIRST_NONSEQ: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (dnHtrans == 2'b10)) else $error("first beat not NONSEQ"); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dnHtrans != 2'b00 && !dnHready) |=> ($stable(dnHaddr) && $stable(dnHsize))) else $error("addr moved in wait"); // R9

  AST_PREFETCH_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqBurst && !reqWrite && reqPrefetch)
      |-> ((int'(reqAddr[OFF_W-1:0]) + (int'(planLen) << planSize)) <= BOUNDARY))
    else $error("prefetch crosses boundary"); // R4

endmodule

// File: tb/access_combiner_test.sv
module access_combiner_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [7:0]  req;
    logic        wr;
    logic [2:0]  sz;
    logic        bst;
    logic [4:0]  len;
    logic        pf;
    logic [31:0] addr;
    logic [7:0]  beats;
    logic [2:0]  esz;
    logic        gap;
  } vec_t;

  // req, wr, sz, bst, len, pf, addr, beats, esz, gap
  localparam vec_t VECS [NVEC] = '{
    '{8'd2, 1'b0, 3'd0, 1'b0, 5'd0,  1'b0, 32'h0000_0103, 8'd1, 3'd0, 1'b0},  // R2 byte read
    '{8'd2, 1'b1, 3'd1, 1'b0, 5'd0,  1'b0, 32'h0000_0202, 8'd1, 3'd1, 1'b0},  // R2 half write
    '{8'd2, 1'b0, 3'd2, 1'b0, 5'd0,  1'b1, 32'h0000_0300, 8'd1, 3'd2, 1'b0},  // R2 word read
    '{8'd3, 1'b0, 3'd3, 1'b0, 5'd0,  1'b0, 32'h0000_0400, 8'd2, 3'd2, 1'b0},  // R3 64-bit
    '{8'd3, 1'b0, 3'd5, 1'b0, 5'd0,  1'b0, 32'h0000_0500, 8'd8, 3'd2, 1'b0},  // R3 256-bit
    '{8'd3, 1'b1, 3'd4, 1'b0, 5'd0,  1'b0, 32'h0000_0600, 8'd4, 3'd2, 1'b0},  // R3 128-bit write
    '{8'd4, 1'b0, 3'd0, 1'b1, 5'd4,  1'b1, 32'h0000_1000, 8'd8, 3'd0, 1'b0},  // R4 buffer limit
    '{8'd4, 1'b0, 3'd1, 1'b1, 5'd8,  1'b1, 32'h0000_101A, 8'd3, 3'd1, 1'b0},  // R4 edge limit
    '{8'd4, 1'b0, 3'd0, 1'b1, 5'd8,  1'b1, 32'h0000_101E, 8'd2, 3'd0, 1'b0},  // R4 near edge
    '{8'd5, 1'b0, 3'd0, 1'b1, 5'd3,  1'b0, 32'h0000_2000, 8'd3, 3'd0, 1'b1},  // R5 byte paced
    '{8'd5, 1'b0, 3'd1, 1'b1, 5'd2,  1'b0, 32'h0000_2100, 8'd2, 3'd1, 1'b1},  // R5 half paced
    '{8'd6, 1'b1, 3'd1, 1'b1, 5'd4,  1'b0, 32'h0000_3000, 8'd4, 3'd1, 1'b0},  // R6 write len
    '{8'd6, 1'b1, 3'd0, 1'b1, 5'd12, 1'b0, 32'h0000_3100, 8'd8, 3'd0, 1'b0},  // R6 fifo cap
    '{8'd6, 1'b1, 3'd0, 1'b1, 5'd3,  1'b1, 32'h0000_311C, 8'd3, 3'd0, 1'b0}   // R6 prefetch flag ignored
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [2:0]  reqSize = '0;
  logic        reqBurst = 1'b0;
  logic [4:0]  reqLen = '0;
  logic        reqPrefetch = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  dnHtrans;
  logic [31:0] dnHaddr;
  logic [2:0]  dnHsize;
  logic [2:0]  dnHburst;
  logic        dnHready = 1'b1;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  access_combiner uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqBurst(reqBurst), .reqLen(reqLen),
    .reqPrefetch(reqPrefetch), .reqAddr(reqAddr), .dnHtrans(dnHtrans),
    .dnHaddr(dnHaddr), .dnHsize(dnHsize), .dnHburst(dnHburst), .dnHready(dnHready)
  );

  task automatic chkBeat(input string tag, input logic [1:0] t, input logic [31:0] a,
                         input logic [2:0] s, input logic rdy);
    checks++;
    if (dnHtrans !== t || dnHaddr !== a || dnHsize !== s || dnHburst !== 3'b001 || reqReady !== rdy) begin
      errors++;
      $display("FAIL %s: actual trans=%b addr=%h size=%0d burst=%b rdy=%b expected trans=%b addr=%h size=%0d burst=001 rdy=%b",
               tag, dnHtrans, dnHaddr, dnHsize, dnHburst, reqReady, t, a, s, rdy);
    end
  endtask

  task automatic chkIdle(input string tag);
    checks++;
    if (dnHtrans !== 2'b00 || dnHburst !== 3'b000 || reqReady !== 1'b1) begin
      errors++;
      $display("FAIL %s: actual trans=%b burst=%b rdy=%b expected trans=00 burst=000 rdy=1",
               tag, dnHtrans, dnHburst, reqReady);
    end
  endtask

  task automatic issue(input logic wr, input logic [2:0] sz, input logic bst,
                       input logic [4:0] len, input logic pf, input logic [31:0] addr);
    @(negedge clk);
    reqWrite = wr; reqSize = sz; reqBurst = bst; reqLen = len;
    reqPrefetch = pf; reqAddr = addr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic runVec(input vec_t v);
    int items;
    string tag;
    items = v.gap ? (2 * int'(v.beats) - 1) : int'(v.beats);
    tag = $sformatf("R%0d/R7 vec@%h", v.req, v.addr);
    issue(v.wr, v.sz, v.bst, v.len, v.pf, v.addr);
    for (int j = 0; j < items; j++) begin
      int beat;
      logic isBusy;
      logic [1:0] et;
      logic [31:0] ea;
      if (j > 0) @(negedge clk);
      beat = v.gap ? j / 2 : j;
      isBusy = v.gap && (j % 2 == 1);
      et = isBusy ? 2'b01 : ((beat == 0) ? 2'b10 : 2'b11);
      ea = v.addr + (32'(isBusy ? beat + 1 : beat) << v.esz);
      chkBeat(tag, et, ea, v.esz, 1'b0);
    end
    @(negedge clk);
    chkIdle({tag, " end R10"});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 reset");

    foreach (VECS[i]) runVec(VECS[i]);

    // R8: zero length paced read gives one beat
    issue(1'b0, 3'd1, 1'b1, 5'd0, 1'b0, 32'h0000_4000);
    chkBeat("R8 zero len", 2'b10, 32'h0000_4000, 3'd1, 1'b0);
    @(negedge clk);
    chkIdle("R8 zero len end");

    // R9: wait states hold the beat
    issue(1'b0, 3'd0, 1'b1, 5'd0, 1'b1, 32'h0000_5000);
    chkBeat("R9 beat0", 2'b10, 32'h0000_5000, 3'd0, 1'b0);
    dnHready = 1'b0;
    @(negedge clk);
    chkBeat("R9 hold1", 2'b10, 32'h0000_5000, 3'd0, 1'b0);
    @(negedge clk);
    chkBeat("R9 hold2", 2'b10, 32'h0000_5000, 3'd0, 1'b0);
    dnHready = 1'b1;
    @(negedge clk);
    chkBeat("R9 resume", 2'b11, 32'h0000_5001, 3'd0, 1'b0);
    for (int k = 0; k < 50 && reqReady !== 1'b1; k++) @(negedge clk);
    chkIdle("R9 drained");

    // R10: request raised mid-transfer is ignored
    issue(1'b0, 3'd0, 1'b1, 5'd2, 1'b0, 32'h0000_2200);
    reqAddr = 32'h0000_7000; reqWrite = 1'b1; reqValid = 1'b1;
    chkBeat("R10 beat0", 2'b10, 32'h0000_2200, 3'd0, 1'b0);
    @(negedge clk);
    chkBeat("R10 gap", 2'b01, 32'h0000_2201, 3'd0, 1'b0);
    reqValid = 1'b0;
    @(negedge clk);
    chkBeat("R10 beat1", 2'b11, 32'h0000_2201, 3'd0, 1'b0);
    @(negedge clk);
    chkIdle("R10 end");
    @(negedge clk);
    chkIdle("R10 no restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule